// File: doc/BRIEF.md
# Clock Pre-Divider Search Engine

This block picks the setting of a small clock pre-divider. It takes a parent clock frequency and a requested output rate, both unsigned values in Hz, and tries every divisor setting in turn. For each setting `p` the divided frequency is the parent frequency divided by `p + 1`, with the fraction dropped. The block keeps the highest divided frequency that is not above the requested rate and reports the setting that produced it. If no setting gives a non-zero frequency at or below the request, it raises a range error.

A single internal restoring shift-subtract divider computes one quotient at a time. A search therefore takes a fixed, known number of cycles. The caller pulses `start_i` while the engine is idle and waits for the one-cycle `done_o` pulse. A separate `parent_ok_i` input marks the parent frequency as known. When it is low at start, the engine finishes at once, reports success and leaves the previous result in place. Loading the chosen setting into a PLL is left to the logic around the block.

Top module: `pdiv_search`

## Requirements
- R1: On a search with a valid parent, `best_div_o` is the setting `p` in 0..2^PDIV_W-1 (0..15 by default) whose truncated quotient floor(parent/(p+1)) is the largest value that does not exceed the target. `best_rate_o` equals that quotient.
- R2: A quotient exactly equal to the target qualifies. A quotient one above the target does not.
- R3: When several settings give the same best quotient, the smallest setting is reported.
- R4: When no setting gives a non-zero quotient at or below the target (for example a target below parent/16, a target of 0, or a parent of 0), `range_err_o` is 1 and both `best_rate_o` and `best_div_o` are 0.
- R5: A start while idle with `parent_ok_i` low gives a `done_o` pulse in the next cycle. In that case `busy_o` stays low, `range_err_o` reads 0, and `best_div_o` and `best_rate_o` keep their previous values.
- R6: `done_o` is high for exactly one cycle per accepted start, and `busy_o` is low while `done_o` is high.
- R7: A start pulse while `busy_o` is high is ignored: the running search finishes with the result for the inputs it captured, and the outputs hold steady while it runs.
- R8: For a valid search, `done_o` rises 2^PDIV_W × (RATE_W+1) cycles after the clock edge that accepted the start (528 for the default sizes).
- R9: After reset, `busy_o`, `done_o` and `range_err_o` are 0, and `best_div_o` and `best_rate_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Search request, sampled only while idle |
| parent_ok_i | input | 1 | Parent frequency is known and valid |
| parent_i | input | RATE_W | Parent clock frequency in Hz |
| target_i | input | RATE_W | Requested rate in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| best_div_o | output | PDIV_W | Chosen setting p (divisor p+1) |
| best_rate_o | output | RATE_W | Divided frequency for the chosen setting |
| range_err_o | output | 1 | No setting qualified |

## Verification
Several kinds of target are applied. Targets set exactly on a divided rate and one below it show whether the comparison is inclusive or strict. A small parent with many equal quotients shows which setting wins a tie. Targets below parent/16, a zero target and a zero parent must raise the error. Random parents paired with targets near parent/k, and fully random targets, test general correctness against a behavioural model. Runs with the parent marked invalid, and a second start injected halfway through a search, show that the previous results are kept and that the captured inputs are not replaced.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

   typedef enum logic [0:0] {
      PS_IDLE = 1'b0,
      PS_RUN  = 1'b1
   } pdiv_state_e;

   // cycles from accepted start to done for a valid search
   function automatic int unsigned search_latency(input int unsigned rate_w,
                                                  input int unsigned pdiv_w);
      return (32'd1 << pdiv_w) * (rate_w + 1);
   endfunction

endpackage

// File: rtl/pdiv_divider.sv
module pdiv_divider #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic [W-1:0] quot_o,
   output logic         done_o
);

   localparam int unsigned CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("pdiv_divider: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  rem_q;
   logic [W-1:0]  quo_q;
   logic [W-1:0]  dv_q;
   logic [CW-1:0] cnt_q;
   logic [W:0]    trial;
   logic [W:0]    diff;

   // partial remainder shifted left with the next dividend bit
   assign trial  = {rem_q, quo_q[W-1]};
   assign diff   = trial - {1'b0, dv_q};
   assign quot_o = quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         dv_q   <= '0;
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            dv_q  <= divisor_i;
            cnt_q <= CW'(W);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (!diff[W]) begin
               rem_q <= diff[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            if (cnt_q == CW'(1)) begin
               done_o <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pdiv_pick.sv
module pdiv_pick #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] cand_rate_i,
   input  logic [W-1:0] limit_i,
   input  logic [W-1:0] best_rate_i,
   output logic         take_o
);

   logic fits;
   logic beats;

   // inclusive limit; strict improvement keeps the earliest on ties
   assign fits   = (cand_rate_i <= limit_i);
   assign beats  = (cand_rate_i > best_rate_i);
   assign take_o = fits && beats;

endmodule

// File: rtl/pdiv_search.sv
module pdiv_search
   import pdiv_pkg::*;
#(
   parameter int unsigned RATE_W = 32,
   parameter int unsigned PDIV_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              parent_ok_i,
   input  logic [RATE_W-1:0] parent_i,
   input  logic [RATE_W-1:0] target_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [PDIV_W-1:0] best_div_o,
   output logic [RATE_W-1:0] best_rate_o,
   output logic              range_err_o
);

   localparam int unsigned CANDS = 1 << PDIV_W;
   localparam logic [PDIV_W-1:0] LAST_CAND = PDIV_W'(CANDS - 1);

   generate
      if (RATE_W <= PDIV_W) begin : g_bad_rate_w
         $error("pdiv_search: RATE_W must exceed PDIV_W");
      end
      if (PDIV_W < 1 || PDIV_W > 8) begin : g_bad_pdiv_w
         $error("pdiv_search: PDIV_W must be in 1..8");
      end
   endgenerate

   pdiv_state_e       state_q;
   logic [RATE_W-1:0] par_q;
   logic [RATE_W-1:0] tgt_q;
   logic [PDIV_W-1:0] cand_q;
   logic [RATE_W-1:0] wrate_q;
   logic [PDIV_W-1:0] wdiv_q;

   logic              accept;
   logic              go;
   logic              last;
   logic              div_start;
   logic              div_done;
   logic [RATE_W-1:0] quo;
   logic [PDIV_W-1:0] nxt_cand;
   logic [RATE_W-1:0] div_a;
   logic [RATE_W-1:0] div_b;
   logic              take;
   logic [RATE_W-1:0] upd_rate;
   logic [PDIV_W-1:0] upd_div;

   assign accept    = (state_q == PS_IDLE) && start_i;
   assign go        = accept && parent_ok_i;
   assign last      = (cand_q == LAST_CAND);
   assign div_start = go || ((state_q == PS_RUN) && div_done && !last);
   assign nxt_cand  = (state_q == PS_IDLE) ? '0 : cand_q + 1'b1;
   assign div_a     = (state_q == PS_IDLE) ? parent_i : par_q;
   assign div_b     = {{(RATE_W-PDIV_W){1'b0}}, nxt_cand} + RATE_W'(1);
   assign upd_rate  = take ? quo : wrate_q;
   assign upd_div   = take ? cand_q : wdiv_q;
   assign busy_o    = (state_q == PS_RUN);

   pdiv_divider #(
      .W (RATE_W)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (div_start),
      .dividend_i (div_a),
      .divisor_i  (div_b),
      .quot_o     (quo),
      .done_o     (div_done)
   );

   pdiv_pick #(
      .W (RATE_W)
   ) u_pick (
      .cand_rate_i (quo),
      .limit_i     (tgt_q),
      .best_rate_i (wrate_q),
      .take_o      (take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PS_IDLE;
         par_q       <= '0;
         tgt_q       <= '0;
         cand_q      <= '0;
         wrate_q     <= '0;
         wdiv_q      <= '0;
         done_o      <= 1'b0;
         best_div_o  <= '0;
         best_rate_o <= '0;
         range_err_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            PS_IDLE: begin
               if (go) begin
                  state_q <= PS_RUN;
                  par_q   <= parent_i;
                  tgt_q   <= target_i;
                  cand_q  <= '0;
                  wrate_q <= '0;
                  wdiv_q  <= '0;
               end else if (accept) begin
                  // no parent clock: finish at once, keep old result
                  done_o      <= 1'b1;
                  range_err_o <= 1'b0;
               end
            end
            PS_RUN: begin
               if (div_done) begin
                  wrate_q <= upd_rate;
                  wdiv_q  <= upd_div;
                  if (last) begin
                     state_q     <= PS_IDLE;
                     done_o      <= 1'b1;
                     best_rate_o <= upd_rate;
                     best_div_o  <= upd_div;
                     range_err_o <= (upd_rate == '0);
                  end else begin
                     cand_q <= cand_q + 1'b1;
                  end
               end
            end
            default: state_q <= PS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pdiv_search_chk.sv
module pdiv_search_chk
   import pdiv_pkg::*;
#(
   parameter int unsigned RATE_W = 32,
   parameter int unsigned PDIV_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              parent_ok_i,
   input logic [RATE_W-1:0] parent_i,
   input logic [RATE_W-1:0] target_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [PDIV_W-1:0] best_div_o,
   input logic [RATE_W-1:0] best_rate_o,
   input logic              range_err_o
);

   localparam int unsigned LAT = search_latency(RATE_W, PDIV_W);

   logic              run_c;
   logic [RATE_W-1:0] par_c;
   logic [RATE_W-1:0] tgt_c;
   logic [31:0]       lat_c;
   logic              acc_c;

   assign acc_c = !busy_o && start_i && parent_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_c <= 1'b0;
         par_c <= '0;
         tgt_c <= '0;
         lat_c <= '0;
      end else begin
         if (acc_c) begin
            run_c <= 1'b1;
            par_c <= parent_i;
            tgt_c <= target_i;
            lat_c <= '0;
         end else begin
            if (busy_o) lat_c <= lat_c + 1;
            if (done_o) run_c <= 1'b0;
         end
      end
   end

   // R1: reported rate is the quotient of the reported setting
   a_r1_quotient: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && run_c && !range_err_o) |->
         (best_rate_o == par_c / (RATE_W'(best_div_o) + RATE_W'(1))));

   // R2: the reported rate never exceeds the captured target
   a_r2_not_above: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && run_c && !range_err_o) |->
         (best_rate_o <= tgt_c && best_rate_o != '0));

   // R4: an error result carries zero setting and zero rate
   a_r4_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && range_err_o) |-> (best_rate_o == '0 && best_div_o == '0));

   // R5: absent parent finishes next cycle with the old result
   a_r5_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !parent_ok_i) |=>
         (done_o && !busy_o && !range_err_o &&
          $stable(best_rate_o) && $stable(best_div_o)));

   // R6: done is a single-cycle pulse outside busy
   a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R7: outputs hold while a search runs
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> ($stable(best_rate_o) && $stable(best_div_o) &&
                  $stable(range_err_o)));

   // R8: fixed search length
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && run_c) |-> (lat_c == LAT));

endmodule

bind pdiv_search pdiv_search_chk #(
   .RATE_W (RATE_W),
   .PDIV_W (PDIV_W)
) u_chk (.*);

// File: tb/pdiv_search_bench.sv
`timescale 1ns/1ps
module pdiv_search_bench;

   localparam int RW  = 32;
   localparam int PW  = 4;
   localparam int LAT = (1 << PW) * (RW + 1);

   typedef struct {
      logic [PW-1:0] d;
      logic [RW-1:0] r;
      logic          e;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          parent_ok_i = 1'b0;
   logic [RW-1:0] parent_i = '0;
   logic [RW-1:0] target_i = '0;
   logic          busy_o;
   logic          done_o;
   logic [PW-1:0] best_div_o;
   logic [RW-1:0] best_rate_o;
   logic          range_err_o;

   int   nchk = 0;
   int   nfail = 0;
   exp_t sbq[$];
   string tagq[$];
   exp_t prev = '{d: '0, r: '0, e: 1'b0};

   always #2 clk = ~clk;

   pdiv_search u_pdiv_search (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .parent_ok_i (parent_ok_i),
      .parent_i    (parent_i),
      .target_i    (target_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .best_div_o  (best_div_o),
      .best_rate_o (best_rate_o),
      .range_err_o (range_err_o)
   );

   function automatic exp_t model(input logic [RW-1:0] par,
                                  input logic [RW-1:0] tgt);
      exp_t x;
      logic [RW-1:0] q;
      x.d = '0;
      x.r = '0;
      for (int p = 0; p < (1 << PW); p++) begin
         q = par / RW'(p + 1);
         if (q <= tgt && q > x.r) begin
            x.r = q;
            x.d = PW'(p);
         end
      end
      x.e = (x.r == '0);
      return x;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // monitor: pop expected result on each done pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sbq.size() == 0) begin
            check(1'b0, "R6", "unexpected done", 1, 0);
         end else begin
            exp_t  x;
            string t;
            x = sbq.pop_front();
            t = tagq.pop_front();
            check(best_div_o == x.d && best_rate_o == x.r && range_err_o == x.e,
                  t, "div/rate/err",
                  {best_div_o, best_rate_o, range_err_o},
                  {x.d, x.r, x.e});
         end
      end
   end

   // driver: one search, optionally with a second start mid-run
   task automatic run_case(input logic [RW-1:0] par, input bit ok,
                           input logic [RW-1:0] tgt, input bit poke,
                           input string tag);
      exp_t x;
      int   n;
      if (ok) x = model(par, tgt);
      else    x = '{d: prev.d, r: prev.r, e: 1'b0};
      prev = x;
      sbq.push_back(x);
      tagq.push_back(tag);
      @(negedge clk);
      parent_i    = par;
      target_i    = tgt;
      parent_ok_i = ok;
      start_i     = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      while (!done_o && n < LAT + 20) begin
         if (n == 1) check(busy_o == 1'b1, "R6", "busy during run", busy_o, 1);
         if (poke && n == 100) begin
            parent_i    = ~par;
            target_i    = $urandom;
            parent_ok_i = 1'b1;
            start_i     = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      // R8 latency (0 for an absent parent, per R5)
      check(n == (ok ? LAT : 0), ok ? "R8" : "R5", "done latency", n, ok ? LAT : 0);
      check(busy_o == 1'b0, "R6", "busy low at done", busy_o, 0);
      @(negedge clk);
      check(done_o == 1'b0, "R6", "done single pulse", done_o, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(busy_o == 0 && done_o == 0 && range_err_o == 0 &&
            best_div_o == 0 && best_rate_o == 0, "R9", "reset outputs",
            {busy_o, done_o, range_err_o, best_div_o, best_rate_o}, 0);

      // R1 general search
      run_case(32'd594000000, 1'b1, 32'd148500000, 1'b0, "R1");
      // R2 target exactly on a divided rate, then one below it
      run_case(32'd1000, 1'b1, 32'd250, 1'b0, "R2");
      run_case(32'd1000, 1'b1, 32'd249, 1'b0, "R2");
      // R3 ties: 20/11 .. 20/16 all give 1, smallest setting wins
      run_case(32'd20, 1'b1, 32'd1, 1'b0, "R3");
      run_case(32'd7, 1'b1, 32'd1, 1'b0, "R3");
      // R4 no candidate: target below parent/16, zero target, zero parent
      run_case(32'd1600, 1'b1, 32'd99, 1'b0, "R4");
      run_case(32'd12345, 1'b1, 32'd0, 1'b0, "R4");
      run_case(32'd0, 1'b1, 32'hFFFFFFFF, 1'b0, "R4");
      // R5 absent parent after an error result, then after a good one
      run_case(32'd5, 1'b0, 32'd5, 1'b0, "R5");
      run_case(32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b0, "R1");
      run_case(32'd0, 1'b0, 32'd0, 1'b0, "R5");
      // R7 second start during a search is ignored
      run_case(32'd297000000, 1'b1, 32'd74250000, 1'b1, "R7");
      run_case(32'd27000000, 1'b1, 32'd1000000, 1'b1, "R7");
      // R1 random targets near parent/k and fully random
      for (int i = 0; i < 12; i++) begin
         logic [RW-1:0] par;
         par = $urandom;
         run_case(par, 1'b1, par / RW'($urandom_range(1, 20)) + RW'($urandom_range(0, 2)),
                  1'b0, "R1");
      end
      for (int i = 0; i < 6; i++) begin
         run_case($urandom, 1'b1, $urandom, 1'b0, "R1");
      end
      repeat (4) @(negedge clk);
      check(sbq.size() == 0, "R6", "missing done pulses", sbq.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule